// File: doc/BRIEF.md
# Fixed-Point Coupled Phase Oscillator Step Engine

This block holds the phases of a small array of coupled oscillators and advances all of them by one forward-Euler step of the noiseless, sine-coupled mean-field phase model whenever a step is requested. Each phase is an unsigned fraction of one full turn: a register of `PH_W` bits, where 2^PH_W stands for 2π, so wrapping into one turn is plain modular overflow.

For the oscillator being updated, the block forms the circular difference to every partner and reads a sine value from a table built at elaboration. It sums those values over all partners and scales the sum by a single coupling constant that already includes the 1/N factor. It then adds that oscillator's natural rate, multiplies by the time step and adds the result to the old phase. The oscillators are processed one per clock, all reading the phases as they stood when the step was accepted. The new set of phases is written in one go, and a one-cycle completion pulse marks that moment.

The defaults give four oscillators with natural rates 0.8, 1.0, 1.1 and 1.3 rad/s, starting phases 0.0, 0.3, 0.6 and 0.9 rad, a coupling of 0.12 and a time step of 0.005, all converted to the fixed-point encodings below.

Top module: `kura_phase_core`

## Requirements
- R1: While `rst_n` is low, the phase registers load `PH_INIT` and `update_done` is 0.
- R2: When `step_en` is high at a rising edge while the block is idle, a step is accepted. The new phases and a `update_done` pulse of exactly one cycle appear together at the N_OSC-th rising edge after the accepting edge.
- R3: A `step_en` that is high while a step is in progress is ignored: it neither starts a second step nor changes the result. The block is idle again one edge after the completion edge.
- R4: Outside the completion edge, `phase_bus` holds its value.
- R5: Every oscillator i is updated as phase_i + ((DT_Q·(omega_i + c_i) + 2^(DT_FB+RATE_FB-1)) >>> (DT_FB+RATE_FB)), taken modulo 2^PH_W. Here omega_i is the signed 32-bit field `OMEGA_Q[32i +: 32]` in phase-LSB per time unit scaled by 2^RATE_FB, and DT_Q is the time step scaled by 2^DT_FB.
- R6: The sine term for the pair (i, j) uses d = (phase_j − phase_i) mod 2^PH_W. Its table address a is the top `LUT_AW` bits of d. With H = 2^(LUT_AW−1) and k = a mod H, the magnitude is floor(16·k(H−k)·2^SIN_FB / (5H² − 4k(H−k))), and it is negated when a ≥ H.
- R7: All oscillators in a step read the phases held before the step, never a value already updated in the same step.
- R8: c_i = (S_i·KN_Q + 2^(SIN_FB−1)) >>> SIN_FB, where S_i is the exact sum of the sine terms over all j (the j = i term is 0) and KN_Q is K/N in the rate encoding.
- R9: With one oscillator and KN_Q = 0, a step adds exactly the rounded DT_Q·omega increment and wraps past 2^PH_W. From 65500 at the default rate of 1.0 rad/s (2670177), one step gives 16.
- R10: Oscillator i's phase occupies `phase_bus[i*PH_W +: PH_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Requests one integration step |
| update_done | output | 1 | One-cycle pulse when all phases have been replaced |
| phase_bus | output | N_OSC*PH_W | Concatenated phase registers, oscillator 0 in the low slot |

## Verification
The checks assume that `step_en` is a synchronous level, sampled only at rising edges. It may be held high for many cycles or toggled on any edge, and no handshake is implied. The stimulus stays within that: it drives `step_en` and `rst_n` only on falling edges. It mixes single pulses, a long stretch with `step_en` held high that overlaps steps in progress, and random requests. Three parameter sets are used: the default array, a single uncoupled oscillator starting just below the wrap point, and a strongly coupled three-oscillator array whose phases lie on both sides of zero, so that the differences wrap.

// File: rtl/kura_pkg.sv
package kura_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } step_state_e;

    // Rational sine approximation over a half turn, scaled by 2^frac.
    function automatic int bhaskara_sin(int k, int half, int frac);
        longint p;
        longint num;
        longint den;
        p   = longint'(k) * longint'(half - k);
        num = (longint'(16) * p) <<< frac;
        den = longint'(5) * longint'(half) * longint'(half) - longint'(4) * p;
        return int'(num / den);
    endfunction

endpackage

// File: rtl/kura_sine_lut.sv
module kura_sine_lut #(
    parameter int LUT_AW = 8,
    parameter int SIN_FB = 14,
    parameter int SIN_W  = SIN_FB + 2
) (
    input  logic [LUT_AW-1:0]       addr,
    output logic signed [SIN_W-1:0] val
);
    localparam int HALF = 2 ** (LUT_AW - 1);

    logic signed [SIN_W-1:0] mag [HALF];

    for (genvar k = 0; k < HALF; k++) begin : g_mag
        assign mag[k] = SIN_W'(kura_pkg::bhaskara_sin(k, HALF, SIN_FB));
    end

    always_comb begin
        if (addr[LUT_AW-1]) begin
            val = -mag[addr[LUT_AW-2:0]];
        end else begin
            val = mag[addr[LUT_AW-2:0]];
        end
    end
endmodule

// File: rtl/kura_osc_eval.sv
module kura_osc_eval #(
    parameter int N_OSC    = 4,
    parameter int PH_W     = 16,
    parameter int LUT_AW   = 8,
    parameter int SIN_FB   = 14,
    parameter int DT_FB    = 16,
    parameter int RATE_FB  = 8,
    parameter logic [N_OSC*32-1:0] OMEGA_Q = '0,
    parameter int KN_Q     = 0,
    parameter int DT_Q     = 0,
    localparam int IW      = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
    input  logic [N_OSC*PH_W-1:0] snap,
    input  logic [IW-1:0]         sel,
    output logic [PH_W-1:0]       phase_out
);
    localparam int SIN_W = SIN_FB + 2;
    localparam int SUM_W = SIN_W + $clog2(N_OSC) + 1;
    localparam logic signed [63:0] CPL_HALF  = 64'sd1 <<< (SIN_FB - 1);
    localparam logic signed [63:0] STEP_HALF = 64'sd1 <<< (DT_FB + RATE_FB - 1);

    logic [PH_W-1:0]         self_ph;
    logic [LUT_AW-1:0]       addr [N_OSC];
    logic signed [SIN_W-1:0] sval [N_OSC];
    logic signed [SUM_W-1:0] acc;
    logic signed [31:0]      omega_i;
    logic signed [63:0]      cpl;
    logic signed [63:0]      rate;
    logic signed [63:0]      incr;

    assign self_ph = snap[int'(sel)*PH_W +: PH_W];
    assign omega_i = OMEGA_Q[int'(sel)*32 +: 32];

    for (genvar j = 0; j < N_OSC; j++) begin : g_pair
        assign addr[j] = LUT_AW'((snap[j*PH_W +: PH_W] - self_ph) >> (PH_W - LUT_AW));
        kura_sine_lut #(
            .LUT_AW(LUT_AW),
            .SIN_FB(SIN_FB),
            .SIN_W (SIN_W)
        ) u_lut (
            .addr(addr[j]),
            .val (sval[j])
        );
    end

    always_comb begin
        acc = '0;
        for (int j = 0; j < N_OSC; j++) begin
            acc = acc + SUM_W'(sval[j]);
        end
        cpl  = (64'(acc) * 64'(KN_Q) + CPL_HALF) >>> SIN_FB;
        rate = 64'(omega_i) + cpl;
        incr = (rate * 64'(DT_Q) + STEP_HALF) >>> (DT_FB + RATE_FB);
        phase_out = self_ph + PH_W'(incr);
    end
endmodule

// File: rtl/kura_phase_core.sv
module kura_phase_core #(
    parameter int N_OSC   = 4,
    parameter int PH_W    = 16,
    parameter int LUT_AW  = 8,
    parameter int SIN_FB  = 14,
    parameter int DT_FB   = 16,
    parameter int RATE_FB = 8,
    parameter logic [N_OSC*32-1:0] OMEGA_Q =
        {32'd3471230, 32'd2937195, 32'd2670177, 32'd2136141},
    parameter logic [N_OSC*PH_W-1:0] PH_INIT =
        {16'd9387, 16'd6258, 16'd3129, 16'd0},
    parameter int KN_Q    = 80105,
    parameter int DT_Q    = 328
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    output logic                    update_done,
    output logic [N_OSC*PH_W-1:0]   phase_bus
);
    localparam int IW   = (N_OSC > 1) ? $clog2(N_OSC) : 1;
    localparam int BUSW = N_OSC * PH_W;
    localparam logic [IW-1:0] LAST = IW'(N_OSC - 1);

    typedef struct packed {
        kura_pkg::step_state_e st;
        logic [IW-1:0]         idx;
        logic [BUSW-1:0]       ph;
        logic [BUSW-1:0]       stage;
        logic                  done;
    } core_s;

    core_s           cur_q;
    core_s           nxt_d;
    logic [PH_W-1:0] eval_phase;

    kura_osc_eval #(
        .N_OSC  (N_OSC),
        .PH_W   (PH_W),
        .LUT_AW (LUT_AW),
        .SIN_FB (SIN_FB),
        .DT_FB  (DT_FB),
        .RATE_FB(RATE_FB),
        .OMEGA_Q(OMEGA_Q),
        .KN_Q   (KN_Q),
        .DT_Q   (DT_Q)
    ) u_eval (
        .snap     (cur_q.ph),
        .sel      (cur_q.idx),
        .phase_out(eval_phase)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        case (cur_q.st)
            kura_pkg::ST_IDLE: begin
                if (step_en) begin
                    nxt_d.st  = kura_pkg::ST_BUSY;
                    nxt_d.idx = '0;
                end
            end
            default: begin
                nxt_d.stage[int'(cur_q.idx)*PH_W +: PH_W] = eval_phase;
                if (cur_q.idx == LAST) begin
                    nxt_d.ph   = nxt_d.stage;
                    nxt_d.done = 1'b1;
                    nxt_d.st   = kura_pkg::ST_IDLE;
                    nxt_d.idx  = '0;
                end else begin
                    nxt_d.idx = cur_q.idx + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st    <= kura_pkg::ST_IDLE;
            cur_q.idx   <= '0;
            cur_q.ph    <= PH_INIT;
            cur_q.stage <= PH_INIT;
            cur_q.done  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign update_done = cur_q.done;
    assign phase_bus   = cur_q.ph;
endmodule

// File: rtl/kura_chk.sv
module kura_chk #(
    parameter int N_OSC = 4,
    parameter int PH_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step_en,
    input logic                  update_done,
    input logic [N_OSC*PH_W-1:0] phase_bus
);
    int busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 0;
        end else if (busy_q > 0) begin
            busy_q <= busy_q - 1;
        end else if (step_en) begin
            busy_q <= N_OSC;
        end
    end

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !update_done |-> $stable(phase_bus));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_done |=> !update_done);

    // R3
    done_from_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_done |-> (busy_q == 0 && $past(busy_q) == 1));

    // R2
    step_yields_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q == 0 && $past(busy_q) == 1) |-> update_done);
endmodule

bind kura_phase_core kura_chk #(
    .N_OSC(N_OSC),
    .PH_W (PH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .update_done(update_done),
    .phase_bus  (phase_bus)
);

// File: tb/tb_kura_phase_core.sv
module kura_ref_model #(
    parameter int N = 4,
    parameter int W = 16,
    parameter int AW = 8,
    parameter int SFB = 14,
    parameter int DFB = 16,
    parameter int RFB = 8,
    parameter logic [N*32-1:0] OMEGA = '0,
    parameter logic [N*W-1:0] INIT = '0,
    parameter int KN = 0,
    parameter int DT = 0,
    parameter string TAG = "m"
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic [N*W-1:0] phase_bus,
    input  logic         update_done,
    output int           n_cmp,
    output int           n_bad
);
    longint ph [N];
    longint pend [N];
    int     busy = 0;
    bit     done_m = 1'b0;
    bit     armed = 1'b0;
    int     cmp_i = 0;
    int     bad_i = 0;
    localparam longint MASK = (longint'(1) << W) - 1;

    assign n_cmp = cmp_i;
    assign n_bad = bad_i;

    // R6: sine law over the address
    function automatic longint sin_ref(longint a);
        longint h, k, p, m;
        h = longint'(1) << (AW - 1);
        k = (a >= h) ? a - h : a;
        p = k * (h - k);
        m = ((longint'(16) * p) <<< SFB) / (5 * h * h - 4 * p);
        return (a >= h) ? -m : m;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ph[i] = longint'(INIT[i*W +: W]);
            busy = 0;
            done_m = 1'b0;
            armed = 1'b1;
        end else begin
            done_m = 1'b0;
            if (busy > 0) begin
                busy = busy - 1;
                if (busy == 0) begin
                    // R7: all slots replaced together from the snapshot
                    for (int i = 0; i < N; i++) ph[i] = pend[i];
                    done_m = 1'b1;
                end
            end else if (step_en) begin
                busy = N;
                for (int i = 0; i < N; i++) begin
                    longint s, c, r, inc;
                    s = 0;
                    for (int j = 0; j < N; j++)
                        s += sin_ref(((ph[j] - ph[i]) & MASK) >> (W - AW));
                    // R8: rounded coupling scale
                    c = (s * longint'(KN) + (longint'(1) <<< (SFB - 1))) >>> SFB;
                    r = longint'(int'(OMEGA[i*32 +: 32])) + c;
                    // R5: rounded Euler increment, wrapped
                    inc = (r * longint'(DT) + (longint'(1) <<< (DFB + RFB - 1))) >>> (DFB + RFB);
                    pend[i] = (ph[i] + inc) & MASK;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (armed && rst_n) begin
            logic [N*W-1:0] exp_bus;
            // R10: slot i at bits i*W
            for (int i = 0; i < N; i++) exp_bus[i*W +: W] = W'(ph[i]);
            cmp_i++;
            if (phase_bus !== exp_bus) begin
                bad_i++;
                $display("FAIL %s %s phase_bus actual=%h expected=%h", TAG,
                         done_m ? "R5/R7 step result" : "R4 hold", phase_bus, exp_bus);
            end
            cmp_i++;
            if (update_done !== done_m) begin
                bad_i++;
                $display("FAIL %s R2/R3 update_done actual=%0b expected=%0b", TAG,
                         update_done, done_m);
            end
        end
    end
endmodule

module tb_kura_phase_core;
    localparam int TCK = 10;

    localparam logic [127:0] OM0 = {32'd3471230, 32'd2937195, 32'd2670177, 32'd2136141};
    localparam logic [63:0]  IN0 = {16'd9387, 16'd6258, 16'd3129, 16'd0};
    localparam logic [31:0]  OM1 = 32'd2670177;
    localparam logic [15:0]  IN1 = 16'd65500;
    localparam logic [95:0]  OM2 = {32'd0, 32'hFFEBA0D0, 32'd2670177};
    localparam logic [47:0]  IN2 = {16'd32768, 16'd300, 16'd65000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_en = 1'b0;
    logic        done0, done1, done2;
    logic [63:0] bus0;
    logic [15:0] bus1;
    logic [47:0] bus2;
    int c0, b0, c1, b1, c2, b2;
    int checks = 0;
    int fails = 0;

    always #(TCK/2) clk = ~clk;

    kura_phase_core dut (.clk(clk), .rst_n(rst_n), .step_en(step_en),
                         .update_done(done0), .phase_bus(bus0));

    kura_phase_core #(.N_OSC(1), .OMEGA_Q(OM1), .PH_INIT(IN1), .KN_Q(0), .DT_Q(328))
        dut_single (.clk(clk), .rst_n(rst_n), .step_en(step_en),
                    .update_done(done1), .phase_bus(bus1));

    kura_phase_core #(.N_OSC(3), .OMEGA_Q(OM2), .PH_INIT(IN2), .KN_Q(800000), .DT_Q(328))
        dut_wrap (.clk(clk), .rst_n(rst_n), .step_en(step_en),
                  .update_done(done2), .phase_bus(bus2));

    kura_ref_model #(.N(4), .OMEGA(OM0), .INIT(IN0), .KN(80105), .DT(328), .TAG("dut"))
        m0 (.clk(clk), .rst_n(rst_n), .step_en(step_en), .phase_bus(bus0),
            .update_done(done0), .n_cmp(c0), .n_bad(b0));
    kura_ref_model #(.N(1), .OMEGA(OM1), .INIT(IN1), .KN(0), .DT(328), .TAG("single"))
        m1 (.clk(clk), .rst_n(rst_n), .step_en(step_en), .phase_bus(bus1),
            .update_done(done1), .n_cmp(c1), .n_bad(b1));
    kura_ref_model #(.N(3), .OMEGA(OM2), .INIT(IN2), .KN(800000), .DT(328), .TAG("wrap"))
        m2 (.clk(clk), .rst_n(rst_n), .step_en(step_en), .phase_bus(bus2),
            .update_done(done2), .n_cmp(c2), .n_bad(b2));

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                 checks + c0 + c1 + c2, fails + b0 + b1 + b2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, R10: slot order
        check("R1 dut bus", longint'(bus0), longint'(IN0));
        check("R10 dut slot0", longint'(bus0[15:0]), 0);
        check("R10 dut slot3", longint'(bus0[63:48]), 9387);
        check("R1 single bus", longint'(bus1), longint'(IN1));
        check("R1 wrap bus", longint'(bus2), longint'(IN2));
        check("R1 done low", longint'({done0, done1, done2}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        repeat (8) @(negedge clk);
        // R9: single uncoupled oscillator wraps 65500 -> 16
        check("R9 single step", longint'(bus1), 16);
        // R3: request held high across busy cycles
        step_en = 1'b1;
        repeat (60) @(negedge clk);
        step_en = 1'b0;
        repeat (6) @(negedge clk);
        // R4, R5, R6, R7, R8: random request pattern, model compared every cycle
        for (int n = 0; n < 2500; n++) begin
            step_en = ($urandom_range(0, 2) == 0);
            @(negedge clk);
        end
        step_en = 1'b0;
        repeat (6) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end
endmodule